// File: doc/BRIEF.md
# Universal Bus Transceiver Channel

This block is a two-way, noninverting data transceiver between an A-side bus and a B-side bus, each of parameterizable width (17 bits by default). The two directions have independent paths. Each path holds one storage word that can act as a transparent latch, a latch closed by its latch enable falling, a register loaded on the rising edge of the path clock, or a register with its clock inhibited. Two control levels, the latch enable and the active-low clock enable, choose the mode. A separate active-low output enable per direction decides whether that direction drives its bus. Driver outputs are given as a data vector with a separate enable, so that the three-state pad sits outside the block.

All controls, including the two path clocks, are sampled by a single system clock. A rising path clock is seen as a low sample followed by a high sample. The block also carries a clock across the buses. The A-side path clock is offered on a clock-out driver, and the clock-out line, as received back from the bus, is offered on a clock-in driver. Each of these drivers is gated by the output enable of its own direction. Both output enables active at once is not allowed. When it happens, an error flag rises and only the A-to-B direction drives.

Reset is asynchronous and active low, and its release is synchronised with two flops. While the synchronised reset is low, both storage words are zero and every driver enable is low.

Top module: `ubt_xcvr`

## Requirements
- R1: With a direction's latch enable high, its output data equals its input data in the same cycle, unchanged in polarity, whatever that direction's path clock and clock enable do.
- R2: With latch enable low and clock enable (active low) low, the storage word loads the input on the system-clock edge at which the path clock is sampled high after being sampled low. From the next cycle on, the output shows that value.
- R3: With latch enable low and clock enable high, path-clock edges are ignored and the output keeps its value.
- R4: When the latch enable falls while the path clock stays static (high before and after), the output holds the input seen in the last cycle the latch enable was high.
- R5: A direction's driver enable is high exactly when its active-low output enable is low (outside reset and conflict); a high output enable makes that direction's drivers high impedance.
- R6: When both output enables are low together, `conflict_err` is 1, the B-side drivers are enabled, and the A-side data and clock-in drivers are disabled.
- R7: `clko_out` carries the A-to-B path clock with `clko_oe` following the A-to-B driver enable; `clki_out` carries `clko_in` with `clki_oe` following the B-to-A driver enable.
- R8: During reset and for two system-clock edges after `rst_n` rises, all driver enables and `conflict_err` are 0; the storage words restart at zero.
- R9: The controls and data of one direction have no effect on the other direction's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all controls |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Data received from the A-side bus |
| b_in | input | W | Data received from the B-side bus |
| ab_lat_en | input | 1 | A-to-B latch enable, high is transparent |
| ab_clk_en_n | input | 1 | A-to-B clock enable, active low |
| ab_clk | input | 1 | A-to-B path clock, sampled |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_lat_en | input | 1 | B-to-A latch enable, high is transparent |
| ba_clk_en_n | input | 1 | B-to-A clock enable, active low |
| ba_clk | input | 1 | B-to-A path clock, sampled |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| clko_in | input | 1 | Clock-out line as received back from the bus |
| b_out | output | W | Data for the B-side drivers |
| b_oe | output | 1 | B-side driver enable |
| a_out | output | W | Data for the A-side drivers |
| a_oe | output | 1 | A-side driver enable |
| clko_out | output | 1 | Clock-out driver data |
| clko_oe | output | 1 | Clock-out driver enable |
| clki_out | output | 1 | Clock-in driver data |
| clki_oe | output | 1 | Clock-in driver enable |
| conflict_err | output | 1 | Both output enables requested together |

## Verification
A wrong storage word becomes visible on the output data in the first cycle its latch enable is low. A missed or spurious path-clock capture shows one cycle after the sampled rising edge, and it stays visible until the next load. Because the random stimulus holds the latch enable low most of the time, any stale or corrupted word is compared against the bench's expected value within a few cycles. Errors in the output-enable arbitration show at once, in the same cycle, on the enable outputs and the error flag.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  typedef enum logic [1:0] {
    M_TRANSP  = 2'd0,
    M_CLOCKED = 2'd1,
    M_INHIBIT = 2'd2
  } path_mode_e;

  typedef struct packed {
    logic lat_en;
    logic clk_en_n;
    logic pclk;
  } path_ctl_t;

  function automatic path_mode_e decode_mode(input logic lat_en, input logic clk_en_n);
    if (lat_en)        return M_TRANSP;
    else if (clk_en_n) return M_INHIBIT;
    else               return M_CLOCKED;
  endfunction

endpackage

// File: rtl/ubt_rst_sync.sv
module ubt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/ubt_oe_arb.sv
module ubt_oe_arb (
  input  logic run,
  input  logic ab_oe_n,
  input  logic ba_oe_n,
  output logic ab_drv,
  output logic ba_drv,
  output logic conflict
);
  always_comb begin
    ab_drv   = run & ~ab_oe_n;
    ba_drv   = run & ~ba_oe_n & ab_oe_n;
    conflict = run & ~ab_oe_n & ~ba_oe_n;
  end
endmodule

// File: rtl/ubt_clk_buf.sv
module ubt_clk_buf (
  input  logic ab_clk,
  input  logic clko_in,
  input  logic ab_drv,
  input  logic ba_drv,
  output logic clko_out,
  output logic clko_oe,
  output logic clki_out,
  output logic clki_oe
);
  always_comb begin
    clko_out = ab_clk;
    clko_oe  = ab_drv;
    clki_out = clko_in;
    clki_oe  = ba_drv;
  end
endmodule

// File: rtl/ubt_path.sv
module ubt_path
  import ubt_pkg::*;
#(
  parameter int W = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  path_ctl_t      ctl,
  input  logic           drv_en,
  input  logic [W-1:0]   d_in,
  output logic [W-1:0]   q_out,
  output logic           q_oe
);
  path_mode_e   mode;
  logic         pclk_q;
  logic         pclk_rise;
  logic         load;
  logic [W-1:0] st_q;

  // next-state decisions
  always_comb begin
    mode      = decode_mode(ctl.lat_en, ctl.clk_en_n);
    pclk_rise = ctl.pclk & ~pclk_q;
    load      = (mode == M_TRANSP) | ((mode == M_CLOCKED) & pclk_rise);
  end

  // previous path-clock sample; reset high so a clock already high is no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pclk_q <= 1'b1;
    else        pclk_q <= ctl.pclk;
  end

  // storage word, one enabled flop per bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st_q[i] <= 1'b0;
      else if (load) st_q[i] <= d_in[i];
    end
  end

  always_comb begin
    q_out = (mode == M_TRANSP) ? d_in : st_q;
    q_oe  = drv_en;
  end
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
  import ubt_pkg::*;
#(
  parameter int W          = 17,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_lat_en,
  input  logic         ab_clk_en_n,
  input  logic         ab_clk,
  input  logic         ab_oe_n,
  input  logic         ba_lat_en,
  input  logic         ba_clk_en_n,
  input  logic         ba_clk,
  input  logic         ba_oe_n,
  input  logic         clko_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic         clko_out,
  output logic         clko_oe,
  output logic         clki_out,
  output logic         clki_oe,
  output logic         conflict_err
);
  logic      rst_s;
  logic      ab_drv;
  logic      ba_drv;
  path_ctl_t ab_ctl;
  path_ctl_t ba_ctl;

  assign ab_ctl = '{lat_en: ab_lat_en, clk_en_n: ab_clk_en_n, pclk: ab_clk};
  assign ba_ctl = '{lat_en: ba_lat_en, clk_en_n: ba_clk_en_n, pclk: ba_clk};

  ubt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  ubt_oe_arb u_arb (
    .run      (rst_s),
    .ab_oe_n  (ab_oe_n),
    .ba_oe_n  (ba_oe_n),
    .ab_drv   (ab_drv),
    .ba_drv   (ba_drv),
    .conflict (conflict_err)
  );

  ubt_path #(.W(W)) u_ab (
    .clk    (clk),
    .rst_n  (rst_s),
    .ctl    (ab_ctl),
    .drv_en (ab_drv),
    .d_in   (a_in),
    .q_out  (b_out),
    .q_oe   (b_oe)
  );

  ubt_path #(.W(W)) u_ba (
    .clk    (clk),
    .rst_n  (rst_s),
    .ctl    (ba_ctl),
    .drv_en (ba_drv),
    .d_in   (b_in),
    .q_out  (a_out),
    .q_oe   (a_oe)
  );

  ubt_clk_buf u_cbuf (
    .ab_clk   (ab_clk),
    .clko_in  (clko_in),
    .ab_drv   (ab_drv),
    .ba_drv   (ba_drv),
    .clko_out (clko_out),
    .clko_oe  (clko_oe),
    .clki_out (clki_out),
    .clki_oe  (clki_oe)
  );
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
  parameter int W = 17
) (
  input logic         clk,
  input logic         rst_s,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_lat_en,
  input logic         ab_clk_en_n,
  input logic         ab_clk,
  input logic         ab_oe_n,
  input logic         ba_lat_en,
  input logic         ba_oe_n,
  input logic         clko_in,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic         clko_out,
  input logic         clko_oe,
  input logic         clki_out,
  input logic         clki_oe,
  input logic         conflict_err
);
  assert_transp_ab_R1: assert property (@(posedge clk) disable iff (!rst_s)
    ab_lat_en |-> (b_out == a_in));
  assert_transp_ba_R1: assert property (@(posedge clk) disable iff (!rst_s)
    ba_lat_en |-> (a_out == b_in));

  assert_clocked_R2: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rst_s) && !ab_lat_en && !ab_clk_en_n && ab_clk && !$past(ab_clk))
    |=> (ab_lat_en || (b_out == $past(a_in))));

  assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rst_s) && !ab_lat_en && !$past(ab_lat_en) && $past(ab_clk_en_n))
    |-> $stable(b_out));

  assert_latched_R4: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rst_s) && $past(ab_lat_en) && !ab_lat_en && ab_clk && $past(ab_clk))
    |-> (b_out == $past(a_in)));

  assert_oe_off_R5: assert property (@(posedge clk) disable iff (!rst_s)
    ab_oe_n |-> (!b_oe && !clko_oe));
  assert_oe_on_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !ab_oe_n |-> b_oe);

  assert_no_dual_drive_R6: assert property (@(posedge clk) disable iff (!rst_s)
    !(a_oe && b_oe));
  assert_conflict_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (!ab_oe_n && !ba_oe_n) |-> (conflict_err && b_oe && !a_oe && !clki_oe));

  assert_clk_out_R7: assert property (@(posedge clk) disable iff (!rst_s)
    clko_oe |-> (clko_out == ab_clk));
  assert_clk_in_R7: assert property (@(posedge clk) disable iff (!rst_s)
    clki_oe |-> (clki_out == clko_in));

  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_s |-> !(a_oe || b_oe || clko_oe || clki_oe || conflict_err));
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_s        (rst_s),
  .a_in         (a_in),
  .b_in         (b_in),
  .ab_lat_en    (ab_lat_en),
  .ab_clk_en_n  (ab_clk_en_n),
  .ab_clk       (ab_clk),
  .ab_oe_n      (ab_oe_n),
  .ba_lat_en    (ba_lat_en),
  .ba_oe_n      (ba_oe_n),
  .clko_in      (clko_in),
  .b_out        (b_out),
  .b_oe         (b_oe),
  .a_out        (a_out),
  .a_oe         (a_oe),
  .clko_out     (clko_out),
  .clko_oe      (clko_oe),
  .clki_out     (clki_out),
  .clki_oe      (clki_oe),
  .conflict_err (conflict_err)
);

// File: tb/ubt_xcvr_bench.sv
module ubt_xcvr_bench;
  localparam int W = 17;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic         ab_lat_en, ab_clk_en_n, ab_clk, ab_oe_n;
  logic         ba_lat_en, ba_clk_en_n, ba_clk, ba_oe_n;
  logic         clko_in;
  logic [W-1:0] b_out, a_out;
  logic         b_oe, a_oe, clko_out, clko_oe, clki_out, clki_oe, conflict_err;

  ubt_xcvr #(.W(W)) u_ubt_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_lat_en(ab_lat_en), .ab_clk_en_n(ab_clk_en_n), .ab_clk(ab_clk), .ab_oe_n(ab_oe_n),
    .ba_lat_en(ba_lat_en), .ba_clk_en_n(ba_clk_en_n), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .clko_in(clko_in), .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe),
    .clko_out(clko_out), .clko_oe(clko_oe), .clki_out(clki_out), .clki_oe(clki_oe),
    .conflict_err(conflict_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // bench model state
  logic [W-1:0] m_ab, m_ba;
  logic         m_abq, m_baq, m_run;
  int           rel_cnt;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] next_word(input logic [W-1:0] st, input logic q,
      input logic lat, input logic cen_n, input logic pc, input logic [W-1:0] d);
    if (lat) return d;
    if (!cen_n && pc && !q) return d;
    return st;
  endfunction

  function automatic string path_tag(input logic lat, input logic cen_n);
    if (lat) return "R1";
    if (cen_n) return "R3";
    return "R2";
  endfunction

  task automatic check_outs();
    logic ab_drv, ba_drv, conf;
    string oe_tag;
    ab_drv = m_run & ~ab_oe_n;
    ba_drv = m_run & ~ba_oe_n & ab_oe_n;
    conf   = m_run & ~ab_oe_n & ~ba_oe_n;
    oe_tag = m_run ? "R5" : "R8";
    chk({oe_tag, " b_oe"}, 32'(b_oe), 32'(ab_drv));
    chk(conf ? "R6 a_oe" : {oe_tag, " a_oe"}, 32'(a_oe), 32'(ba_drv));
    chk(m_run ? "R6 flag" : "R8 flag", 32'(conflict_err), 32'(conf));
    chk("R7 clko_oe", 32'(clko_oe), 32'(ab_drv));
    chk("R7 clki_oe", 32'(clki_oe), 32'(ba_drv));
    if (ab_drv) chk("R7 clko_out", 32'(clko_out), 32'(ab_clk));
    if (ba_drv) chk("R7 clki_out", 32'(clki_out), 32'(clko_in));
    if (m_run) begin
      chk({path_tag(ab_lat_en, ab_clk_en_n), " b_out"}, 32'(b_out), 32'(ab_lat_en ? a_in : m_ab));
      chk({path_tag(ba_lat_en, ba_clk_en_n), " a_out"}, 32'(a_out), 32'(ba_lat_en ? b_in : m_ba));
    end
  endtask

  task automatic update_model();
    if (m_run) begin
      m_ab  = next_word(m_ab, m_abq, ab_lat_en, ab_clk_en_n, ab_clk, a_in);
      m_ba  = next_word(m_ba, m_baq, ba_lat_en, ba_clk_en_n, ba_clk, b_in);
      m_abq = ab_clk;
      m_baq = ba_clk;
    end else begin
      m_ab = '0; m_ba = '0; m_abq = 1'b1; m_baq = 1'b1;
    end
    if (rst_n) begin
      rel_cnt++;
      if (rel_cnt >= 2) m_run = 1'b1;
    end else begin
      rel_cnt = 0;
      m_run   = 1'b0;
    end
  endtask

  // inputs change at posedge+1, checked at posedge+4, model follows the edge
  task automatic step();
    #3;
    check_outs();
    @(posedge clk);
    #1;
    update_model();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    a_in = '0; b_in = '0; clko_in = 1'b0;
    ab_lat_en = 1'b0; ab_clk_en_n = 1'b1; ab_clk = 1'b0; ab_oe_n = 1'b0;
    ba_lat_en = 1'b0; ba_clk_en_n = 1'b1; ba_clk = 1'b0; ba_oe_n = 1'b0;
    m_ab = '0; m_ba = '0; m_abq = 1'b1; m_baq = 1'b1; m_run = 1'b0; rel_cnt = 0;

    // R8: enables requested during reset stay off
    @(posedge clk); #1;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R8 b_oe one edge after release", 32'(b_oe), 32'd0);
    step();
    step();
    chk("R8 storage zero", 32'(b_out), 32'd0);
    chk("R8 storage zero", 32'(a_out), 32'd0);
    ab_oe_n = 1'b1; ba_oe_n = 1'b1;
    step();

    // R1 transparent, clock held high
    ab_oe_n = 1'b0; ab_lat_en = 1'b1; ab_clk = 1'b1; a_in = 17'h1A5A5;
    #1 chk("R1 transparent", 32'(b_out), 32'h1A5A5);
    step();
    // R4 latch closes, input moves
    ab_lat_en = 1'b0; a_in = 17'h00F0F;
    step();
    chk("R4 latched hold", 32'(b_out), 32'h1A5A5);
    step();
    chk("R4 latched hold later", 32'(b_out), 32'h1A5A5);

    // R2 clocked capture
    ab_clk_en_n = 1'b0; ab_clk = 1'b0;
    step();
    a_in = 17'h13C3C; ab_clk = 1'b1;
    step();
    chk("R2 captured on rise", 32'(b_out), 32'h13C3C);

    // R3 inhibit
    ab_clk_en_n = 1'b1; a_in = 17'h07777;
    for (int k = 0; k < 6; k++) begin
      ab_clk = ~ab_clk;
      step();
    end
    chk("R3 inhibited hold", 32'(b_out), 32'h13C3C);

    // R9 independence: B-to-A stays put while A-to-B churns
    b_in = 17'h0AAAA; ba_lat_en = 1'b1;
    step();
    ba_lat_en = 1'b0; b_in = 17'h05555;
    step();
    held = a_out;
    for (int k = 0; k < 5; k++) begin
      ab_lat_en = k[0]; ab_clk_en_n = k[1]; ab_clk = ~ab_clk; a_in = W'($urandom());
      step();
    end
    chk("R9 other direction", 32'(a_out), 32'(held));
    chk("R9 other direction value", 32'(a_out), 32'h0AAAA);

    // R6 conflict
    ab_oe_n = 1'b0; ba_oe_n = 1'b0;
    step();
    chk("R6 flag", 32'(conflict_err), 32'd1);
    chk("R6 a side off", 32'(a_oe), 32'd0);
    // R7 clock-in path alone
    ab_oe_n = 1'b1; clko_in = 1'b1;
    step();
    chk("R7 clki copy", 32'(clki_out & clki_oe), 32'd1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      a_in        = W'($urandom());
      b_in        = W'($urandom());
      ab_lat_en   = ($urandom_range(3) == 0);
      ba_lat_en   = ($urandom_range(3) == 0);
      ab_clk_en_n = ($urandom_range(2) == 0);
      ba_clk_en_n = ($urandom_range(2) == 0);
      ab_clk      = 1'($urandom());
      ba_clk      = 1'($urandom());
      ab_oe_n     = 1'($urandom());
      ba_oe_n     = ($urandom_range(3) != 0);
      clko_in     = 1'($urandom());
      step();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule